// File: doc/BRIEF.md
# Shader Operand Relative-Addressing Unit

This block keeps the index registers of a small shader-style processor and works out the effective constant index of the first source operand of each instruction. Two registers are loaded by software. An address-load strobe writes them from two 32-bit floating-point values, and each value is converted to a signed integer on the way in. The third register is a loop counter. Only the loop sequencer writes it. It keeps its value once a loop has finished, so later instructions can still use it.

Each instruction arrives with a format flag and a 32-bit word. For a format-1 instruction, a 2-bit select field in that word chooses which register offsets the source constant index. The select can also choose no offset at all. The result is registered. An out-of-range flag goes with it when the sum falls outside the constant window.

Top module: `opnd_reladdr`

## Requirements
- R1: A synchronous active-high reset clears both address registers and the loop counter to zero and drops `eff_valid`. The first instructions after reset therefore see a zero offset for every select value.
- R2: The index select is `ins_word[20:19]`. The value 0 adds no offset, so the source index `ins_word[6:0]` comes out unchanged.
- R3: For a format-1 instruction, select 1 adds address register 0, select 2 adds address register 1 and select 3 adds the loop counter, each as a signed 8-bit value.
- R4: When `ins_fmt1` is low, the source index passes through unchanged whatever the select field holds.
- R5: An address load writes register 0 from `arl_x` and register 1 from `arl_y`. An instruction in the same cycle still sees the old values. The next instruction sees the new ones.
- R6: The float-to-integer conversion truncates toward zero (3.7 gives 3, -2.9 gives -2, 0.5 gives 0).
- R7: A NaN converts to 0. Infinities and magnitudes beyond the 8-bit signed range saturate to 127 or -128 (-128.5 gives -128, 127.9 gives 127).
- R8: The loop counter changes only when `lc_we` is high. It holds its value for any number of cycles without writes.
- R9: `eff_valid`, `eff_idx` and `eff_oor` appear exactly one clock after the instruction is presented. `eff_valid` is low after a cycle with no instruction.
- R10: If the sum lies outside 0 to 95, `eff_idx` is the sum modulo 128 and `eff_oor` is high. Otherwise `eff_oor` is low.
- R11: With select 2, address register 1 equal to 3 and source index 8, the effective index is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arl_we | input | 1 | Address-register load strobe |
| arl_x | input | 32 | Float value for address register 0 |
| arl_y | input | 32 | Float value for address register 1 |
| lc_we | input | 1 | Loop-counter write strobe from the loop sequencer |
| lc_val | input | 8 | Signed loop-counter value |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_fmt1 | input | 1 | Instruction is format 1 |
| ins_word | input | 32 | Instruction word (select at [20:19], source index at [6:0]) |
| eff_valid | output | 1 | Effective index valid |
| eff_idx | output | 7 | Effective source constant index |
| eff_oor | output | 1 | Sum fell outside the constant window |

## Verification
The bench builds the block with its default parameters: 8-bit registers, a 7-bit index and a 96-entry window. With these values every saturation limit and every edge of the window can be reached with a few hand-picked floats and indices. A negative register plus a small index reaches the low wrap. A large index plus a positive offset crosses 95 while staying under 128, and also goes past 127. Float encodings on both sides of -128 and 127 exercise the clamp against the exact truncation.

// File: rtl/reladdr_pkg.sv
package reladdr_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_AR0  = 2'd1,
    SEL_AR1  = 2'd2,
    SEL_LOOP = 2'd3
  } idx_sel_e;

  localparam int INS_W     = 32;
  localparam int FP_W      = 32;
  localparam int FP_FRAC_W = 23;
  localparam int FP_EXP_W  = 8;
  localparam int FP_BIAS   = 127;

endpackage

// File: rtl/f2s_conv.sv
module f2s_conv
  import reladdr_pkg::*;
#(
  parameter int AR_W = 8
) (
  input  logic [FP_W-1:0]        fval,
  output logic signed [AR_W-1:0] ival
);

  localparam int SIG_W = FP_FRAC_W + 1;
  localparam logic [SIG_W-1:0] POS_LIM = SIG_W'((1 << (AR_W - 1)) - 1);
  localparam logic [SIG_W-1:0] NEG_LIM = SIG_W'(1 << (AR_W - 1));
  localparam logic signed [AR_W-1:0] MAXV = AR_W'((1 << (AR_W - 1)) - 1);
  localparam logic signed [AR_W-1:0] MINV = AR_W'(1 << (AR_W - 1));

  function automatic logic signed [AR_W-1:0] to_fixed(input logic [FP_W-1:0] f);
    logic                    sgn;
    logic [FP_EXP_W-1:0]     ex;
    logic [FP_FRAC_W-1:0]    fr;
    logic [SIG_W-1:0]        mag;
    int                      sh;
    logic signed [AR_W-1:0]  res;
    sgn = f[FP_W-1];
    ex  = f[FP_W-2 -: FP_EXP_W];
    fr  = f[FP_FRAC_W-1:0];
    mag = '0;
    res = '0;
    sh  = int'(ex) - FP_BIAS;
    if (ex == '1 && fr != '0) begin
      res = '0;
    end else if (sh < 0) begin
      res = '0;
    end else if (sh >= AR_W) begin
      res = sgn ? MINV : MAXV;
    end else begin
      mag = {1'b1, fr} >> (FP_FRAC_W - sh);
      if (!sgn) res = (mag > POS_LIM) ? MAXV : mag[AR_W-1:0];
      else      res = (mag > NEG_LIM) ? MINV : AR_W'(-mag[AR_W-1:0]);
    end
    return res;
  endfunction

  assign ival = to_fixed(fval);

endmodule

// File: rtl/addr_regs.sv
module addr_regs #(
  parameter int AR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_en,
  input  logic signed [AR_W-1:0] ld_a0,
  input  logic signed [AR_W-1:0] ld_a1,
  input  logic                   lc_en,
  input  logic signed [AR_W-1:0] lc_in,
  output logic signed [AR_W-1:0] a0_q,
  output logic signed [AR_W-1:0] a1_q,
  output logic signed [AR_W-1:0] lc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a0_q <= '0;
      a1_q <= '0;
    end else if (ld_en) begin
      a0_q <= ld_a0;
      a1_q <= ld_a1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        lc_q <= '0;
    else if (lc_en) lc_q <= lc_in;
  end

endmodule

// File: rtl/eff_calc.sv
module eff_calc
  import reladdr_pkg::*;
#(
  parameter int AR_W      = 8,
  parameter int IDX_W     = 7,
  parameter int IDX_LIMIT = 96
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_fmt1,
  input  idx_sel_e               in_sel,
  input  logic [IDX_W-1:0]       in_src,
  input  logic signed [AR_W-1:0] a0,
  input  logic signed [AR_W-1:0] a1,
  input  logic signed [AR_W-1:0] lc,
  output logic                   out_valid,
  output logic [IDX_W-1:0]       out_idx,
  output logic                   out_oor
);

  localparam int WIDE  = (IDX_W + 1 > AR_W) ? IDX_W + 1 : AR_W;
  localparam int SUM_W = WIDE + 1;

  function automatic logic signed [AR_W-1:0] pick_off(
    input logic fmt1, input idx_sel_e sel,
    input logic signed [AR_W-1:0] r0, input logic signed [AR_W-1:0] r1,
    input logic signed [AR_W-1:0] rl);
    logic signed [AR_W-1:0] o;
    o = '0;
    if (fmt1) begin
      case (sel)
        SEL_AR0:  o = r0;
        SEL_AR1:  o = r1;
        SEL_LOOP: o = rl;
        default:  o = '0;
      endcase
    end
    return o;
  endfunction

  function automatic logic signed [SUM_W-1:0] add_off(
    input logic [IDX_W-1:0] s, input logic signed [AR_W-1:0] o);
    logic signed [SUM_W-1:0] se, oe;
    se = $signed({{(SUM_W-IDX_W){1'b0}}, s});
    oe = $signed({{(SUM_W-AR_W){o[AR_W-1]}}, o});
    return se + oe;
  endfunction

  function automatic logic outside(input logic signed [SUM_W-1:0] v);
    return v[SUM_W-1] || (v >= $signed(SUM_W'(IDX_LIMIT)));
  endfunction

  logic signed [AR_W-1:0]  off_sel;
  logic signed [SUM_W-1:0] sum_full;
  logic                    sum_bad;

  assign off_sel  = pick_off(in_fmt1, in_sel, a0, a1, lc);
  assign sum_full = add_off(in_src, off_sel);
  assign sum_bad  = outside(sum_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_oor   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_idx <= sum_full[IDX_W-1:0];
        out_oor <= sum_bad;
      end
    end
  end

endmodule

// File: rtl/opnd_reladdr.sv
module opnd_reladdr
  import reladdr_pkg::*;
#(
  parameter int AR_W      = 8,
  parameter int IDX_W     = 7,
  parameter int IDX_LIMIT = 96,
  parameter int SEL_LSB   = 19,
  parameter int SRC_LSB   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arl_we,
  input  logic [31:0]      arl_x,
  input  logic [31:0]      arl_y,
  input  logic             lc_we,
  input  logic [AR_W-1:0]  lc_val,
  input  logic             ins_valid,
  input  logic             ins_fmt1,
  input  logic [31:0]      ins_word,
  output logic             eff_valid,
  output logic [IDX_W-1:0] eff_idx,
  output logic             eff_oor
);

  localparam int NCONV = 2;

  logic [FP_W-1:0]        conv_in  [NCONV];
  logic signed [AR_W-1:0] conv_out [NCONV];
  logic signed [AR_W-1:0] a0_q, a1_q, lc_q;
  idx_sel_e               ins_sel;
  logic [IDX_W-1:0]       ins_src;
  logic                   unused_ins;

  assign conv_in[0] = arl_x;
  assign conv_in[1] = arl_y;

  for (genvar gi = 0; gi < NCONV; gi++) begin : g_conv
    f2s_conv #(.AR_W(AR_W)) u_conv (
      .fval (conv_in[gi]),
      .ival (conv_out[gi])
    );
  end

  assign ins_sel    = idx_sel_e'(ins_word[SEL_LSB +: 2]);
  assign ins_src    = ins_word[SRC_LSB +: IDX_W];
  assign unused_ins = ^ins_word;

  addr_regs #(.AR_W(AR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .ld_en (arl_we),
    .ld_a0 (conv_out[0]),
    .ld_a1 (conv_out[1]),
    .lc_en (lc_we),
    .lc_in ($signed(lc_val)),
    .a0_q  (a0_q),
    .a1_q  (a1_q),
    .lc_q  (lc_q)
  );

  eff_calc #(.AR_W(AR_W), .IDX_W(IDX_W), .IDX_LIMIT(IDX_LIMIT)) u_calc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ins_valid),
    .in_fmt1   (ins_fmt1),
    .in_sel    (ins_sel),
    .in_src    (ins_src),
    .a0        (a0_q),
    .a1        (a1_q),
    .lc        (lc_q),
    .out_valid (eff_valid),
    .out_idx   (eff_idx),
    .out_oor   (eff_oor)
  );

endmodule

// File: rtl/reladdr_chk.sv
module reladdr_chk #(
  parameter int AR_W      = 8,
  parameter int IDX_W     = 7,
  parameter int IDX_LIMIT = 96
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   arl_we,
  input logic                   lc_we,
  input logic [AR_W-1:0]        lc_val,
  input logic                   ins_valid,
  input logic                   ins_fmt1,
  input logic [1:0]             sel,
  input logic [IDX_W-1:0]       src,
  input logic signed [AR_W-1:0] new_a0,
  input logic signed [AR_W-1:0] new_a1,
  input logic signed [AR_W-1:0] a0_q,
  input logic signed [AR_W-1:0] a1_q,
  input logic signed [AR_W-1:0] lc_q,
  input logic                   eff_valid,
  input logic [IDX_W-1:0]       eff_idx,
  input logic                   eff_oor
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> eff_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> !eff_valid); // R9
  AST_SEL_NONE_PASS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && sel == 2'd0) |=> (eff_idx == $past(src))); // R2
  AST_OTHER_FMT_PASS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_fmt1) |=> (eff_idx == $past(src))); // R4
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (eff_valid && !eff_oor) |-> (int'(eff_idx) < IDX_LIMIT)); // R10
  AST_ARL_LOAD: assert property (@(posedge clk) disable iff (rst)
    arl_we |=> (a0_q == $past(new_a0) && a1_q == $past(new_a1))); // R5
  AST_ARL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !arl_we |=> ($stable(a0_q) && $stable(a1_q))); // R5
  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !lc_we |=> $stable(lc_q)); // R8
  AST_LOOP_LOAD: assert property (@(posedge clk) disable iff (rst)
    lc_we |=> (lc_q == $signed($past(lc_val)))); // R8

endmodule

bind opnd_reladdr reladdr_chk #(.AR_W(AR_W), .IDX_W(IDX_W), .IDX_LIMIT(IDX_LIMIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .arl_we    (arl_we),
  .lc_we     (lc_we),
  .lc_val    (lc_val),
  .ins_valid (ins_valid),
  .ins_fmt1  (ins_fmt1),
  .sel       (ins_word[SEL_LSB +: 2]),
  .src       (ins_src),
  .new_a0    (conv_out[0]),
  .new_a1    (conv_out[1]),
  .a0_q      (a0_q),
  .a1_q      (a1_q),
  .lc_q      (lc_q),
  .eff_valid (eff_valid),
  .eff_idx   (eff_idx),
  .eff_oor   (eff_oor)
);

// File: tb/sim_opnd_reladdr.sv
`timescale 1ns/1ps
module sim_opnd_reladdr;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arl_we = 1'b0, lc_we = 1'b0, ins_valid = 1'b0, ins_fmt1 = 1'b0;
  logic [31:0] arl_x = '0, arl_y = '0, ins_word = '0;
  logic [7:0]  lc_val = '0;
  logic        eff_valid, eff_oor;
  logic [6:0]  eff_idx;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_a0 = 0, m_a1 = 0, m_lc = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  opnd_reladdr u0 (
    .clk(clk), .rst(rst), .arl_we(arl_we), .arl_x(arl_x), .arl_y(arl_y),
    .lc_we(lc_we), .lc_val(lc_val), .ins_valid(ins_valid), .ins_fmt1(ins_fmt1),
    .ins_word(ins_word), .eff_valid(eff_valid), .eff_idx(eff_idx), .eff_oor(eff_oor)
  );

  function automatic int fconv(input logic [31:0] f);
    int e;
    real v;
    e = int'(f[30:23]);
    if (e == 255) return (f[22:0] != 0) ? 0 : (f[31] ? -128 : 127);
    if (e == 0) return 0;
    v = 1.0 + real'(f[22:0]) / 8388608.0;
    for (int k = 0; k < e - 127 && k < 40; k++) v = v * 2.0;
    for (int k = 0; k < 127 - e; k++) v = v / 2.0;
    if (f[31]) v = -v;
    if (v >= 128.0) return 127;
    if (v <= -129.0) return -128;
    return $rtoi(v);
  endfunction

  function automatic logic [31:0] mk(input int sel, input int src);
    return (32'hB4C5_2A80 & 32'hFFE7_FF80) | (32'(sel) << 19) | 32'(src);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit aw, input logic [31:0] x, input logic [31:0] y,
                      input bit lw, input int lv, input bit iv, input bit fm, input logic [31:0] w);
    int sel, src, off, sum, e_idx;
    bit e_oor;
    arl_we = aw; arl_x = x; arl_y = y;
    lc_we = lw; lc_val = 8'(lv);
    ins_valid = iv; ins_fmt1 = fm; ins_word = w;
    sel = int'(w[20:19]);
    src = int'(w[6:0]);
    off = 0;
    if (fm) off = (sel == 1) ? m_a0 : (sel == 2) ? m_a1 : (sel == 3) ? m_lc : 0;
    sum = src + off;
    e_idx = ((sum % 128) + 128) % 128;
    e_oor = (sum < 0) || (sum > 95);
    if (aw) begin m_a0 = fconv(x); m_a1 = fconv(y); end
    if (lw) m_lc = (lv > 127) ? lv - 256 : lv;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "eff_valid", int'(eff_valid), int'(iv));
    if (iv) begin
      chk(tag, "eff_idx", int'(eff_idx), e_idx);
      chk(tag, "eff_oor", int'(eff_oor), int'(e_oor));
    end
  endtask

  task automatic ins(input string tag, input bit fm, input int sel, input int src);
    step(tag, 0, 0, 0, 0, 0, 1, fm, mk(sel, src));
  endtask

  task automatic arl(input string tag, input logic [31:0] x, input logic [31:0] y);
    step(tag, 1, x, y, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "eff_valid in reset", int'(eff_valid), 0);
    rst = 1'b0;
    ins("R1", 1, 1, 5);
    ins("R1", 1, 2, 5);
    ins("R1", 1, 3, 5);
    arl("R5", 32'h4040_0000, 32'hC0A0_0000);       // 3.0, -5.0
    ins("R2", 1, 0, 40);
    ins("R3", 1, 1, 10);
    ins("R3", 1, 2, 10);
    // load and instruction in the same cycle: old values used
    step("R5", 1, 32'h4120_0000, 32'h4000_0000, 0, 0, 1, 1, mk(1, 20));
    ins("R5", 1, 1, 20);
    ins("R5", 1, 2, 20);
    arl("R6", 32'h406C_CCCD, 32'hC039_999A);       // 3.7, -2.9
    ins("R6", 1, 1, 0);
    ins("R6", 1, 2, 50);
    arl("R6", 32'h3F00_0000, 32'hBF40_0000);       // 0.5, -0.75
    ins("R6", 1, 1, 7);
    ins("R6", 1, 2, 7);
    arl("R7", 32'h7FC0_0000, 32'h7F80_0000);       // NaN, +inf
    ins("R7", 1, 1, 9);
    ins("R7", 1, 2, 9);
    arl("R7", 32'h447A_0000, 32'hC47A_0000);       // 1000, -1000
    ins("R7", 1, 1, 0);
    ins("R7", 1, 2, 0);
    arl("R7", 32'hC300_8000, 32'h42FF_CCCD);       // -128.5, 127.9
    ins("R7", 1, 1, 0);
    ins("R7", 1, 2, 0);
    arl("R4", 32'h4120_0000, 32'h4120_0000);       // 10, 10
    ins("R4", 0, 1, 33);
    ins("R4", 0, 3, 120);
    step("R8", 0, 0, 0, 1, 7, 0, 0, 0);
    for (int i = 0; i < 6; i++) ins("R8", 1, 3, 30 + i);
    step("R8", 0, 0, 0, 1, 250, 1, 1, mk(3, 4));
    ins("R8", 1, 3, 4);
    step("R9", 0, 0, 0, 0, 0, 0, 1, mk(1, 3));
    ins("R9", 1, 1, 3);
    arl("R10", 32'hC0A0_0000, 32'h4120_0000);      // -5, 10
    ins("R10", 1, 1, 2);
    ins("R10", 1, 2, 90);
    ins("R10", 1, 2, 85);
    ins("R10", 1, 2, 86);
    ins("R10", 1, 2, 125);
    ins("R10", 1, 0, 100);
    arl("R11", 32'h3F80_0000, 32'h4040_0000);      // 1.0, 3.0
    ins("R11", 1, 2, 8);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2, r3;
      seed = seed * 32'd1664525 + 32'd1013904223; r1 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; r2 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; r3 = seed;
      step("R3", r1[0] & r1[1], {r2[31], 4'b1000, r2[26:0]}, {r3[31], 4'b1000, r3[26:0]},
           r1[2] & r1[3], int'(r1[15:8]), r1[4], r1[5], r3);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule